// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block is the decision logic of one eight-line interrupt controller. It receives the pending request bits, the enable mask, the in-service bits and a rotating priority base. From these it works out whether a new interrupt should be raised toward the processor and, if so, which line wins. Priority is not fixed. The line named by the rotation offset is the most urgent, the next line up comes second, and the order wraps around past line 7.

A request is raised only when it outranks everything already in service. Two mode flags change which in-service bits count toward that comparison. The first is a special-mask mode, which drops in-service bits whose lines are masked. The second is a nested mode, which drops the cascade line (line 2) when the unit is the master of a cascade. The same priority encoder is also applied to the raw in-service bits, so that end-of-interrupt handling can learn which in-service line ranks highest.

The block is purely combinational. Its registers, its bus access and the cascading between controllers all live outside it.

Top module: `irq_prio_resolver`

## Requirements
- R1: The priority level of a bit vector is the smallest p in 0..7 for which bit ((p + rot_i) mod 8) is set. An empty vector has level 8 (none). Among the candidates, the one with the lowest level wins.
- R2: The candidates are irr_i AND NOT imr_i. A request whose imr_i bit is 1 never wins, and when there are no candidates req_valid_o is 0.
- R3: The service level is the level of the effective in-service vector. req_valid_o is 1 only when the candidate level is strictly less than the service level, so a request at the same level as an in-service line is blocked.
- R4: When special_mask_i is 1, in-service bits whose imr_i bit is 1 are removed before the service level is computed. When special_mask_i is 0, all in-service bits count.
- R5: When nested_i and master_i are both 1, in-service bit 2 is ignored for the service level. With master_i at 0, bit 2 counts as normal.
- R6: req_line_o equals (candidate level + rot_i) mod 8 when req_valid_o is 1, and is 0 otherwise.
- R7: int_o is 1 exactly when req_valid_o is 1.
- R8: eoi_valid_o is 1 when isr_i is nonzero. eoi_line_o is the in-service line with the lowest level under rot_i, taken from the raw isr_i with no mode masking, and is 0 when isr_i is empty.
- R9: All outputs are a combinational function of the present inputs, with no storage, so they follow an input change within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irr_i | input | 8 | Pending request bits |
| imr_i | input | 8 | Enable mask, 1 = line masked |
| isr_i | input | 8 | In-service bits |
| rot_i | input | 3 | Rotation base: the line with top priority |
| special_mask_i | input | 1 | Drop masked lines from the service comparison |
| nested_i | input | 1 | Nested mode: ignore the cascade line in service when master |
| master_i | input | 1 | 1 = this unit is the cascade master |
| req_valid_o | output | 1 | A request outranks the current service |
| req_line_o | output | 3 | Winning line number |
| int_o | output | 1 | Interrupt output to the processor |
| eoi_valid_o | output | 1 | At least one line is in service |
| eoi_line_o | output | 3 | Highest-priority in-service line |

## Verification
Whenever the inputs are known, the bound checker confirms four things. A winning line is a pending, unmasked request. No candidate outranks it under the current rotation. No effective in-service bit ranks at or above it once the special-mask and nested modes are applied. The end-of-interrupt line is in service and ranks highest. Whether the right line wins out of all of them, how the two mode flags combine with master_i, and the exact line under each of the eight rotation offsets can only be shown by the bench. It does this with hand-picked vectors and a reference model driven with random request, mask and in-service values.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NUM_LINES    = 8;
  localparam int unsigned CASCADE_LINE = 2;
endpackage

// File: rtl/prio_level_enc.sv
// Level = distance from the rotation base to the first set bit; N when empty.
module prio_level_enc #(
  parameter int unsigned N = irq_prio_pkg::NUM_LINES,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] mask_i,
  input  logic [W-1:0] rot_i,
  output logic [W:0]   level_o
);
  logic [N-1:0] rel_mask;

  for (genvar p = 0; p < N; p++) begin : g_rel
    assign rel_mask[p] = mask_i[W'(p) + rot_i];
  end

  always_comb begin
    level_o = (W+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rel_mask[p]) level_o = (W+1)'(p);
    end
  end
endmodule

// File: rtl/prio_service_mask.sv
// Effective in-service vector used for the nesting comparison.
module prio_service_mask #(
  parameter int unsigned N       = irq_prio_pkg::NUM_LINES,
  parameter int unsigned CASCADE = irq_prio_pkg::CASCADE_LINE
) (
  input  logic [N-1:0] isr_i,
  input  logic [N-1:0] imr_i,
  input  logic         special_mask_i,
  input  logic         nested_i,
  input  logic         master_i,
  output logic [N-1:0] svc_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    if (i == CASCADE) begin : g_casc
      assign svc_o[i] = isr_i[i] & ~(special_mask_i & imr_i[i]) & ~(nested_i & master_i);
    end else begin : g_norm
      assign svc_o[i] = isr_i[i] & ~(special_mask_i & imr_i[i]);
    end
  end
endmodule

// File: rtl/prio_compare.sv
// Converts a level back to a line; valid only when strictly above the limit level.
module prio_compare #(
  parameter int unsigned N = irq_prio_pkg::NUM_LINES,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [W:0]   level_i,
  input  logic [W:0]   limit_i,
  input  logic [W-1:0] rot_i,
  output logic         valid_o,
  output logic [W-1:0] line_o
);
  assign valid_o = level_i < limit_i;
  assign line_o  = valid_o ? level_i[W-1:0] + rot_i : '0;
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int unsigned N       = irq_prio_pkg::NUM_LINES,
  parameter int unsigned CASCADE = irq_prio_pkg::CASCADE_LINE,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] irr_i,
  input  logic [N-1:0] imr_i,
  input  logic [N-1:0] isr_i,
  input  logic [W-1:0] rot_i,
  input  logic         special_mask_i,
  input  logic         nested_i,
  input  logic         master_i,
  output logic         req_valid_o,
  output logic [W-1:0] req_line_o,
  output logic         int_o,
  output logic         eoi_valid_o,
  output logic [W-1:0] eoi_line_o
);
  localparam logic [W:0] LVL_NONE = (W+1)'(N);

  logic [N-1:0] cand;
  logic [N-1:0] svc;
  logic [W:0]   req_level;
  logic [W:0]   svc_level;
  logic [W:0]   eoi_level;

  assign cand = irr_i & ~imr_i;

  prio_service_mask #(.N(N), .CASCADE(CASCADE)) u_svc_mask (
    .isr_i          (isr_i),
    .imr_i          (imr_i),
    .special_mask_i (special_mask_i),
    .nested_i       (nested_i),
    .master_i       (master_i),
    .svc_o          (svc)
  );

  prio_level_enc #(.N(N)) u_req_enc (.mask_i(cand),  .rot_i(rot_i), .level_o(req_level));
  prio_level_enc #(.N(N)) u_svc_enc (.mask_i(svc),   .rot_i(rot_i), .level_o(svc_level));
  prio_level_enc #(.N(N)) u_eoi_enc (.mask_i(isr_i), .rot_i(rot_i), .level_o(eoi_level));

  prio_compare #(.N(N)) u_req_cmp (
    .level_i (req_level),
    .limit_i (svc_level),
    .rot_i   (rot_i),
    .valid_o (req_valid_o),
    .line_o  (req_line_o)
  );

  // Any occupied level beats the empty sentinel.
  prio_compare #(.N(N)) u_eoi_cmp (
    .level_i (eoi_level),
    .limit_i (LVL_NONE),
    .rot_i   (rot_i),
    .valid_o (eoi_valid_o),
    .line_o  (eoi_line_o)
  );

  assign int_o = req_valid_o;
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int unsigned N       = irq_prio_pkg::NUM_LINES,
  parameter int unsigned CASCADE = irq_prio_pkg::CASCADE_LINE,
  localparam int unsigned W = $clog2(N)
) (
  input logic [N-1:0] irr_i,
  input logic [N-1:0] imr_i,
  input logic [N-1:0] isr_i,
  input logic [W-1:0] rot_i,
  input logic         special_mask_i,
  input logic         nested_i,
  input logic         master_i,
  input logic         req_valid_o,
  input logic [W-1:0] req_line_o,
  input logic         int_o,
  input logic         eoi_valid_o,
  input logic [W-1:0] eoi_line_o
);
  // True if some set bit of m sits ahead of (or at, when incl) relative slot rel.
  function automatic logic ahead(input logic [N-1:0] m, input logic [W-1:0] rot,
                                 input logic [W-1:0] rel, input logic incl);
    logic r;
    r = 1'b0;
    for (int q = 0; q < N; q++) begin
      if ((W'(q) < rel || (incl && W'(q) == rel)) && m[W'(q) + rot]) r = 1'b1;
    end
    return r;
  endfunction

  logic [N-1:0] eff_isr;
  logic [W-1:0] req_rel;
  logic [W-1:0] eoi_rel;

  always_comb begin
    eff_isr = isr_i;
    if (special_mask_i) eff_isr = eff_isr & ~imr_i;
    if (nested_i && master_i) eff_isr[CASCADE] = 1'b0;
    req_rel = req_line_o - rot_i;
    eoi_rel = eoi_line_o - rot_i;
  end

  always_comb begin
    if (!$isunknown({irr_i, imr_i, isr_i, rot_i, special_mask_i, nested_i, master_i,
                     req_valid_o, req_line_o, int_o, eoi_valid_o, eoi_line_o})) begin
      p_line_unmasked_r2: assert (!req_valid_o || (irr_i[req_line_o] && !imr_i[req_line_o]))
        else $error("winner not an enabled request");
      p_line_top_r1: assert (!req_valid_o || !ahead(irr_i & ~imr_i, rot_i, req_rel, 1'b0))
        else $error("higher candidate skipped");
      p_beats_service_r3: assert (!req_valid_o || !ahead(eff_isr, rot_i, req_rel, 1'b1))
        else $error("winner does not beat service (R4/R5 masking applied)");
      p_idle_line_r6: assert (req_valid_o || req_line_o == '0)
        else $error("line nonzero while idle");
      p_int_valid_r7: assert (int_o == req_valid_o)
        else $error("int disagrees with valid");
      p_eoi_top_r8: assert (!eoi_valid_o ||
                            (isr_i[eoi_line_o] && !ahead(isr_i, rot_i, eoi_rel, 1'b0)))
        else $error("eoi line not top in-service");
      p_eoi_empty_r8: assert (eoi_valid_o == (isr_i != '0))
        else $error("eoi valid mismatch");
    end
  end
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.N(N), .CASCADE(CASCADE)) u_chk (
  .irr_i          (irr_i),
  .imr_i          (imr_i),
  .isr_i          (isr_i),
  .rot_i          (rot_i),
  .special_mask_i (special_mask_i),
  .nested_i       (nested_i),
  .master_i       (master_i),
  .req_valid_o    (req_valid_o),
  .req_line_o     (req_line_o),
  .int_o          (int_o),
  .eoi_valid_o    (eoi_valid_o),
  .eoi_line_o     (eoi_line_o)
);

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irr, imr, isr;
  logic [2:0] rot;
  logic       smm, nst, mst;
  logic       req_valid, int_w, eoi_valid;
  logic [2:0] req_line, eoi_line;
  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_resolver u_dut (
    .irr_i(irr), .imr_i(imr), .isr_i(isr), .rot_i(rot),
    .special_mask_i(smm), .nested_i(nst), .master_i(mst),
    .req_valid_o(req_valid), .req_line_o(req_line), .int_o(int_w),
    .eoi_valid_o(eoi_valid), .eoi_line_o(eoi_line)
  );

  // {irr, imr, isr, rot, smm, nested, master, exp_valid, exp_line}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {8'h01, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R1 base
    {8'h81, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7}, // R1 R6 rotation
    {8'h0F, 8'h0F, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R2 all masked
    {8'h10, 8'h00, 8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R3 equal level blocked
    {8'h08, 8'h00, 8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3}, // R3 higher wins
    {8'h20, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R3 lower blocked
    {8'h20, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd5}, // R5 master ignores bit 2
    {8'h20, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0}, // R5 slave keeps bit 2
    {8'h20, 8'h04, 8'h04, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5}, // R4 special mask on
    {8'h20, 8'h04, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R4 special mask off
    {8'h09, 8'h00, 8'h02, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R1 R6 rot 5
    {8'h41, 8'h00, 8'h02, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R1 R6 rot 7 wrap
    {8'hC0, 8'h00, 8'h80, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R3 top in service
    {8'h06, 8'h02, 8'h00, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2}  // R2 masked top skipped
  };

  function automatic int lvl(input logic [7:0] m, input logic [2:0] r);
    for (int p = 0; p < 8; p++) if (m[(p + r) % 8]) return p;
    return 8;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, b, c, input logic [2:0] r,
                       input logic s, n, m);
    @(posedge clk);
    irr = a; imr = b; isr = c; rot = r; smm = s; nst = n; mst = m;
    @(negedge clk);
  endtask

  task automatic model_check();
    logic [7:0] e;
    int rl, sl, el;
    logic v;
    e = isr;
    if (smm) e = e & ~imr;
    if (nst && mst) e[2] = 1'b0;
    rl = lvl(irr & ~imr, rot);
    sl = lvl(e, rot);
    el = lvl(isr, rot);
    v = rl < sl;
    check("R3 valid", int'(req_valid), int'(v));
    check("R6 line", int'(req_line), v ? (rl + rot) % 8 : 0);
    check("R7 int", int'(int_w), int'(v));
    check("R8 eoi", int'({eoi_valid, eoi_line}),
          int'({el < 8, el < 8 ? 3'((el + rot) % 8) : 3'd0}));
  endtask

  initial begin
    irr = '0; imr = '0; isr = '0; rot = '0; smm = 0; nst = 0; mst = 0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state with all inputs clear
    check("R2 idle valid", int'(req_valid), 0);
    check("R7 idle int", int'(int_w), 0);
    check("R8 idle eoi", int'(eoi_valid), 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][33:26], VEC[i][25:18], VEC[i][17:10], VEC[i][9:7],
            VEC[i][6], VEC[i][5], VEC[i][4]);
      check($sformatf("R1-vec%0d valid", i), int'(req_valid), int'(VEC[i][3]));
      check($sformatf("R6 vec%0d line", i), int'(req_line), int'(VEC[i][2:0]));
      check($sformatf("R7 vec%0d int", i), int'(int_w), int'(VEC[i][3]));
    end

    // R8: eoi uses raw isr, unaffected by modes
    apply(8'h00, 8'h04, 8'h14, 3'd3, 1'b1, 1'b1, 1'b1);
    check("R8 eoi line rot3", int'(eoi_line), 4);
    apply(8'h00, 8'h00, 8'h14, 3'd5, 1'b0, 1'b0, 1'b0);
    check("R8 eoi line rot5", int'(eoi_line), 2);

    // R9: output follows input change without an extra cycle
    @(posedge clk);
    irr = 8'h40; imr = 8'h00; isr = 8'h00; rot = 3'd0; smm = 0; nst = 0; mst = 0;
    #1;
    check("R9 same-cycle line", int'(req_line), 6);
    check("R9 same-cycle valid", int'(req_valid), 1);

    // R1 R4 R5 random sweep across every rotation
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 150; k++) begin
        apply(8'($urandom), 8'($urandom), 8'($urandom), 3'(r),
              1'($urandom), 1'($urandom), 1'($urandom));
        model_check();
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule